// File: doc/BRIEF.md
# Touch Controller Power-State and Interrupt Registers

This block holds the host-visible control and status registers of a multi-channel capacitive touch controller. A host reaches it through a plain register port: an address, write data, a write strobe and a combinational read-data output, plus a one-cycle pulse that marks any bus transaction addressed to the device. An abstract scanning engine reports per-channel touch and release events; the block accepts them only for channels it currently allows to be scanned, and it drives the scan mask back to that engine.

The block keeps a sticky status bit per channel, a sticky release flag per channel and the live touch state. It raises an active-low alert when a touch lands on a channel whose interrupt enable is set. It raises a wake output when such a touch happens in standby. The host acknowledges by writing zero to the interrupt flag. Standby narrows scanning to a host-chosen channel subset. Deep sleep stops scanning altogether and empties the status. Any bus transaction ends deep sleep.

Top module: `tsc_regctl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) the control register reads 00h, interrupt enables read 3Fh, the standby mask reads 00h, status, touch state and release flags read 00h, alert_n is 1, wake is 0 and scan_en is all ones.
- R2: The control register at address 00h holds standby in bit 5, deep sleep in bit 4 and the interrupt flag in bit 0; bits 7, 6, 3, 2 and 1 always read 0.
- R3: Defined addresses are 01h interrupt enables (RW), 02h standby channel mask (RW), 03h sticky status (RO), 04h live touch state (RO), 05h sticky release flags (RO), with channel n in bit n. Any other address outside 00h and FDh-FFh reads 00h, and a write to it changes no register.
- R4: Addresses FDh, FEh and FFh read the fixed product (3Ch), vendor (5Ah) and revision (01h) values, and writes to them change nothing.
- R5: scan_en is all ones when standby and deep sleep are 0, equals the standby mask when standby is 1 and deep sleep is 0, and is all zeros when deep sleep is 1.
- R6: Touch and release events on a channel whose scan_en bit is 0 are ignored. A touched channel whose scan_en bit goes from 1 to 0 sets its release flag once and reads not-touched from the next edge on.
- R7: A touch event on a scanned channel sets its status bit and touch-state bit on the next edge. A release clears only the touch-state bit; status is never cleared by a release, in standby or not.
- R8: A touch event on a scanned channel with its enable bit 1 sets the interrupt flag and drives alert_n low on the next edge; alert_n equals the inverse of the interrupt flag. A touch on a channel with enable 0 raises no alert.
- R9: Writing 00h with bit 0 clear deasserts alert_n and wake on the next edge, clears the status bits of channels not touched at that time, keeps those of touched channels, and clears all release flags. Writing bit 0 as 1 leaves the interrupt flag unchanged.
- R10: A touch that raises the interrupt while standby is 1 also drives wake to 1 on the next edge.
- R11: While deep sleep reads 1, the next edge clears status, touch state, release flags, the interrupt flag and wake.
- R12: A bus_act pulse clears deep sleep on the next edge unless the same cycle writes address 00h, in which case the written value wins.
- R13: When an interrupt-raising touch and a write of 0 to the interrupt flag fall in the same cycle, the interrupt flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| bus_act | input | 1 | One-cycle pulse per bus transaction to this device |
| rdata | output | 8 | Read data for addr (combinational) |
| touch_evt | input | 6 | Per-channel touch event pulses |
| rel_evt | input | 6 | Per-channel release event pulses |
| scan_en | output | 6 | Channels the scanning engine may sample |
| alert_n | output | 1 | Active-low interrupt output |
| wake | output | 1 | Standby wake indication |

## Verification
A wrong internal bit here surfaces at the ports within one clock: the interrupt flag and wake are registered straight onto alert_n and wake, the power bits feed scan_en combinationally, and every per-channel register is readable through rdata in the same cycle its address is presented. A stale touch-state bit shows first as a status bit that survives an acknowledge it should not, or that vanishes when it should stay, so the bench acknowledges often with channels held in both states. Drop-out releases show as a release flag and cleared touch bit one edge after scan_en narrows.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam logic [7:0] A_CTRL = 8'h00;
   localparam logic [7:0] A_IEN  = 8'h01;
   localparam logic [7:0] A_SBYM = 8'h02;
   localparam logic [7:0] A_STS  = 8'h03;
   localparam logic [7:0] A_TCH  = 8'h04;
   localparam logic [7:0] A_RELF = 8'h05;
   localparam logic [7:0] A_PROD = 8'hFD;
   localparam logic [7:0] A_VEND = 8'hFE;
   localparam logic [7:0] A_REV  = 8'hFF;

   localparam int B_SBY = 5;
   localparam int B_DS  = 4;
   localparam int B_INT = 0;

   typedef struct packed {
      logic sby;
      logic ds;
      logic irq;
      logic wake;
   } pwr_state_t;
endpackage

// File: rtl/tsc_ctrl_reg.sv
module tsc_ctrl_reg
   import tsc_pkg::*;
#(
   parameter int NCH    = 6,
   parameter int AW     = 8,
   parameter int DW     = 8,
   parameter logic [NCH-1:0] IEN_RST = '1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata,
   input  logic           wr_en,
   input  logic           bus_act,
   input  logic           hit,
   output pwr_state_t     pst,
   output logic           int_clr,
   output logic [NCH-1:0] ien,
   output logic [NCH-1:0] sbym
);
   logic wr_ctrl;
   assign wr_ctrl = wr_en && (addr == AW'(A_CTRL));
   assign int_clr = wr_ctrl && !wdata[B_INT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pst  <= '0;
         ien  <= IEN_RST;
         sbym <= '0;
      end else begin
         if (wr_ctrl) begin
            pst.sby <= wdata[B_SBY];
            pst.ds  <= wdata[B_DS];
         end else if (bus_act) begin
            pst.ds <= 1'b0;
         end
         if (wr_en && addr == AW'(A_IEN))  ien  <= wdata[NCH-1:0];
         if (wr_en && addr == AW'(A_SBYM)) sbym <= wdata[NCH-1:0];
         if (pst.ds) begin
            pst.irq  <= 1'b0;
            pst.wake <= 1'b0;
         end else begin
            if (hit)          pst.irq <= 1'b1;
            else if (int_clr) pst.irq <= 1'b0;
            if (hit && pst.sby) pst.wake <= 1'b1;
            else if (int_clr)   pst.wake <= 1'b0;
         end
      end
   end

   p_int_wr1_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && wdata[B_INT] && !hit && !pst.irq) |=> !pst.irq);
   p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pst.ds |=> (!pst.irq && !pst.wake));
   p_busact_wake_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_act && !wr_ctrl) |=> !pst.ds);
   p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !pst.ds) |=> pst.irq);
endmodule

// File: rtl/tsc_chan_bank.sv
module tsc_chan_bank #(
   parameter int NCH = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] scan,
   input  logic [NCH-1:0] touch_evt,
   input  logic [NCH-1:0] rel_evt,
   input  logic [NCH-1:0] ien,
   input  logic           sleep,
   input  logic           int_clr,
   output logic [NCH-1:0] touched,
   output logic [NCH-1:0] status,
   output logic [NCH-1:0] relf,
   output logic           hit
);
   logic [NCH-1:0] scan_q;
   logic [NCH-1:0] acc_t;
   logic [NCH-1:0] acc_r;
   logic [NCH-1:0] drop;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign acc_t[i] = touch_evt[i] && scan[i];
      assign drop[i]  = scan_q[i] && !scan[i] && touched[i];
      assign acc_r[i] = (rel_evt[i] && scan[i]) || drop[i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            touched[i] <= 1'b0;
            status[i]  <= 1'b0;
            relf[i]    <= 1'b0;
            scan_q[i]  <= 1'b1;
         end else begin
            scan_q[i] <= scan[i];
            if (sleep) begin
               touched[i] <= 1'b0;
               status[i]  <= 1'b0;
               relf[i]    <= 1'b0;
            end else begin
               if (!scan[i])      touched[i] <= 1'b0;
               else if (acc_t[i]) touched[i] <= 1'b1;
               else if (acc_r[i]) touched[i] <= 1'b0;
               if (acc_t[i])                     status[i] <= 1'b1;
               else if (int_clr && !touched[i])  status[i] <= 1'b0;
               if (acc_r[i])     relf[i] <= 1'b1;
               else if (int_clr) relf[i] <= 1'b0;
            end
         end
      end

      p_dropout_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (drop[i] && !sleep) |=> (!touched[i] && relf[i]));
      p_unscanned_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !scan[i] |=> !touched[i]);
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] && !sleep && !int_clr) |=> status[i]);
   end

   assign hit = |(acc_t & ien);

   p_sleep_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (status == '0 && relf == '0 && touched == '0));
endmodule

// File: rtl/tsc_rd_mux.sv
module tsc_rd_mux
   import tsc_pkg::*;
#(
   parameter int NCH = 6,
   parameter int AW  = 8,
   parameter int DW  = 8,
   parameter logic [7:0] PROD_ID = 8'h3C,
   parameter logic [7:0] VEND_ID = 8'h5A,
   parameter logic [7:0] REV_ID  = 8'h01
) (
   input  logic [AW-1:0]  addr,
   input  pwr_state_t     pst,
   input  logic [NCH-1:0] ien,
   input  logic [NCH-1:0] sbym,
   input  logic [NCH-1:0] status,
   input  logic [NCH-1:0] touched,
   input  logic [NCH-1:0] relf,
   output logic [DW-1:0]  rdata
);
   logic [DW-1:0] ctrl_word;

   always_comb begin
      ctrl_word          = '0;
      ctrl_word[B_SBY]   = pst.sby;
      ctrl_word[B_DS]    = pst.ds;
      ctrl_word[B_INT]   = pst.irq;
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(A_CTRL))      rdata = ctrl_word;
      else if (addr == AW'(A_IEN))  rdata = DW'(ien);
      else if (addr == AW'(A_SBYM)) rdata = DW'(sbym);
      else if (addr == AW'(A_STS))  rdata = DW'(status);
      else if (addr == AW'(A_TCH))  rdata = DW'(touched);
      else if (addr == AW'(A_RELF)) rdata = DW'(relf);
      else if (addr == AW'(A_PROD)) rdata = DW'(PROD_ID);
      else if (addr == AW'(A_VEND)) rdata = DW'(VEND_ID);
      else if (addr == AW'(A_REV))  rdata = DW'(REV_ID);
   end
endmodule

// File: rtl/tsc_regctl.sv
module tsc_regctl
   import tsc_pkg::*;
#(
   parameter int NCH = 6,
   parameter int AW  = 8,
   parameter int DW  = 8,
   parameter logic [NCH-1:0] IEN_RST = '1,
   parameter logic [7:0] PROD_ID = 8'h3C,
   parameter logic [7:0] VEND_ID = 8'h5A,
   parameter logic [7:0] REV_ID  = 8'h01
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata,
   input  logic           wr_en,
   input  logic           bus_act,
   output logic [DW-1:0]  rdata,
   input  logic [NCH-1:0] touch_evt,
   input  logic [NCH-1:0] rel_evt,
   output logic [NCH-1:0] scan_en,
   output logic           alert_n,
   output logic           wake
);
   if (NCH < 1 || NCH > DW) begin : g_bad_nch
      $error("NCH must lie in 1..DW");
   end
   if (AW < 8) begin : g_bad_aw
      $error("AW must be at least 8");
   end
   if (DW < 8) begin : g_bad_dw
      $error("DW must be at least 8");
   end

   pwr_state_t     pst;
   logic           int_clr;
   logic           hit;
   logic [NCH-1:0] ien, sbym, status, touched, relf;

   always_comb begin
      if (pst.ds)       scan_en = '0;
      else if (pst.sby) scan_en = sbym;
      else              scan_en = '1;
   end

   tsc_ctrl_reg #(.NCH(NCH), .AW(AW), .DW(DW), .IEN_RST(IEN_RST)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .bus_act(bus_act), .hit(hit), .pst(pst), .int_clr(int_clr),
      .ien(ien), .sbym(sbym));

   tsc_chan_bank #(.NCH(NCH)) u_bank (
      .clk(clk), .rst_n(rst_n), .scan(scan_en), .touch_evt(touch_evt),
      .rel_evt(rel_evt), .ien(ien), .sleep(pst.ds), .int_clr(int_clr),
      .touched(touched), .status(status), .relf(relf), .hit(hit));

   tsc_rd_mux #(.NCH(NCH), .AW(AW), .DW(DW), .PROD_ID(PROD_ID),
                .VEND_ID(VEND_ID), .REV_ID(REV_ID)) u_rd (
      .addr(addr), .pst(pst), .ien(ien), .sbym(sbym), .status(status),
      .touched(touched), .relf(relf), .rdata(rdata));

   assign alert_n = !pst.irq;
   assign wake    = pst.wake;

   p_alert_on_touch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(touch_evt & scan_en & ien)) |=> !alert_n);
   p_sleep_no_scan_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(A_CTRL) && wdata[B_DS]) |=> (scan_en == '0));
   p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int_clr && !hit) |=> (alert_n && !wake));
endmodule

// File: tb/sim_tsc_regctl.sv
`timescale 1ns/1ps
module sim_tsc_regctl;
   localparam int CYC = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0, wdata = '0, rdata;
   logic       wr_en = 1'b0, bus_act = 1'b0;
   logic [5:0] touch_evt = '0, rel_evt = '0, scan_en;
   logic       alert_n, wake;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // bench model state
   bit       m_sb, m_ds, m_int, m_wake;
   bit [5:0] m_ie, m_sbm, m_sts, m_tch, m_rf, m_scanp;

   always #(CYC/2) clk = ~clk;

   tsc_regctl u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .bus_act(bus_act), .rdata(rdata), .touch_evt(touch_evt),
      .rel_evt(rel_evt), .scan_en(scan_en), .alert_n(alert_n), .wake(wake));

   function automatic bit [5:0] m_scan();
      if (m_ds) return 6'h00;
      if (m_sb) return m_sbm;
      return 6'h3F;
   endfunction

   function automatic bit [7:0] m_read(input bit [7:0] a);
      case (a)
         8'h00: return {2'b00, m_sb, m_ds, 3'b000, m_int};
         8'h01: return {2'b00, m_ie};
         8'h02: return {2'b00, m_sbm};
         8'h03: return {2'b00, m_sts};
         8'h04: return {2'b00, m_tch};
         8'h05: return {2'b00, m_rf};
         8'hFD: return 8'h3C;
         8'hFE: return 8'h5A;
         8'hFF: return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

   task automatic m_reset();
      m_sb = 0; m_ds = 0; m_int = 0; m_wake = 0;
      m_ie = 6'h3F; m_sbm = 0; m_sts = 0; m_tch = 0; m_rf = 0; m_scanp = 6'h3F;
   endtask

   task automatic m_step(input bit w, input bit [7:0] a, input bit [7:0] d,
                         input bit ba, input bit [5:0] t, input bit [5:0] r);
      bit [5:0] sc, at, ar;
      bit hit, clr;
      sc  = m_scan();
      at  = t & sc;
      ar  = (r & sc) | (m_scanp & ~sc & m_tch);
      hit = |(at & m_ie);
      clr = w && a == 8'h00 && !d[0];
      if (m_ds) begin
         m_sts = 0; m_rf = 0; m_tch = 0; m_int = 0; m_wake = 0;
      end else begin
         m_sts  = at | (clr ? (m_sts & m_tch) : m_sts);
         m_rf   = ar | (clr ? 6'h00 : m_rf);
         m_tch  = ((m_tch & ~ar) | at) & sc;
         m_wake = (hit && m_sb) || (!clr && m_wake);
         m_int  = hit || (!clr && m_int);
      end
      m_scanp = sc;
      if (w && a == 8'h00) begin m_sb = d[5]; m_ds = d[4]; end
      else if (ba) m_ds = 0;
      if (w && a == 8'h01) m_ie  = d[5:0];
      if (w && a == 8'h02) m_sbm = d[5:0];
   endtask

   task automatic chk(input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one cycle: check outputs, drive, check read data, advance model
   task automatic step(input string tag, input bit w, input bit [7:0] a,
                       input bit [7:0] d, input bit ba,
                       input bit [5:0] t, input bit [5:0] r);
      @(negedge clk);
      chk(tag, "alert_n/wake/scan_en", {8'h00, alert_n, wake, scan_en},
          {8'h00, !m_int, m_wake, m_scan()});
      wr_en = w; addr = a; wdata = d; bus_act = ba; touch_evt = t; rel_evt = r;
      #1;
      chk(tag, $sformatf("rdata@%h", a), {8'h00, rdata}, {8'h00, m_read(a)});
      m_step(w, a, d, ba, t, r);
   endtask

   task automatic rd(input string tag, input bit [7:0] a);
      step(tag, 0, a, 8'h00, 0, 0, 0);
   endtask

   task automatic wr(input string tag, input bit [7:0] a, input bit [7:0] d);
      step(tag, 1, a, d, 1, 0, 0);
   endtask

   initial begin
      repeat (CYC * 200000 / CYC) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20451));
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 R2 R4: reset values and fixed identification
      rd("R1", 8'h00); rd("R1", 8'h01); rd("R1", 8'h02); rd("R1", 8'h03);
      rd("R1", 8'h04); rd("R1", 8'h05);
      rd("R4", 8'hFD); rd("R4", 8'hFE); rd("R4", 8'hFF);
      // R2: spare control bits stay zero
      wr("R2", 8'h00, 8'hCE); rd("R2", 8'h00);
      wr("R2", 8'h00, 8'h00); rd("R2", 8'h00);
      // R3: undefined addresses
      wr("R3", 8'h10, 8'hFF); rd("R3", 8'h10); rd("R3", 8'h06);
      rd("R3", 8'h01); rd("R3", 8'h02);
      // R4: writes to identification ignored
      wr("R4", 8'hFD, 8'h00); rd("R4", 8'hFD);
      wr("R4", 8'hFF, 8'hAA); rd("R4", 8'hFF);
      // R7 R8: touch channel 1, then release
      step("R7", 0, 8'h03, 0, 0, 6'h02, 0); rd("R8", 8'h03); rd("R7", 8'h04);
      step("R7", 0, 8'h04, 0, 0, 0, 6'h02); rd("R7", 8'h03); rd("R7", 8'h05);
      // R9: writing 1 leaves the flag; touch ch2 held, then acknowledge
      wr("R9", 8'h00, 8'h01); rd("R9", 8'h00);
      step("R9", 0, 8'h03, 0, 0, 6'h04, 0);
      wr("R9", 8'h00, 8'h00); rd("R9", 8'h03); rd("R9", 8'h05);
      // R8: disabled channel 0 raises no alert
      wr("R8", 8'h01, 8'h3E);
      step("R8", 0, 8'h03, 0, 0, 6'h01, 0); rd("R8", 8'h00); rd("R8", 8'h03);
      // R5 R6 R10: standby on channel 3, channel 2 drops out
      wr("R5", 8'h02, 8'h08); wr("R5", 8'h00, 8'h20);
      rd("R6", 8'h04); rd("R6", 8'h05);
      step("R6", 0, 8'h03, 0, 0, 6'h10, 6'h08); rd("R6", 8'h04);
      step("R10", 0, 8'h03, 0, 0, 6'h08, 0); rd("R10", 8'h00);
      wr("R9", 8'h00, 8'h20); rd("R9", 8'h03);
      // R13: raise and acknowledge in the same cycle
      step("R13", 1, 8'h00, 8'h20, 1, 6'h08, 0); rd("R13", 8'h00);
      // R11 R12: deep sleep via write with bus_act, then bus_act ends it
      step("R12", 1, 8'h00, 8'h10, 1, 0, 0); rd("R11", 8'h00);
      rd("R11", 8'h03); rd("R11", 8'h05);
      step("R11", 0, 8'h03, 0, 0, 6'h3F, 0); rd("R11", 8'h04);
      step("R12", 0, 8'h00, 0, 1, 0, 0); rd("R12", 8'h00);
      step("R12", 1, 8'h01, 8'h3F, 1, 0, 0); rd("R12", 8'h01);

      // mixed random traffic against the bench model
      for (int k = 0; k < 5000; k++) begin
         bit w, ba;
         bit [7:0] a, d;
         bit [5:0] t, r;
         int sel;
         sel = $urandom_range(0, 11);
         case (sel)
            0, 1, 2, 3, 4, 5: a = 8'(sel);
            6: a = 8'hFD; 7: a = 8'hFE; 8: a = 8'hFF;
            default: a = 8'($urandom);
         endcase
         w  = ($urandom_range(0, 5) == 0);
         d  = 8'($urandom);
         if (a == 8'h00 && $urandom_range(0, 3) != 0) d[4] = 1'b0;
         ba = w || ($urandom_range(0, 7) == 0);
         t  = ($urandom_range(0, 2) == 0) ? 6'($urandom) & 6'($urandom) : 6'h00;
         r  = ($urandom_range(0, 2) == 0) ? 6'($urandom) : 6'h00;
         step("R3/R7/R9 random", w, a, d, ba, t, r);
      end

      rd("R1 final", 8'h00);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule